// File: doc/BRIEF.md
# DDR2 Power-Up Bring-Up Sequencer

This block brings a DDR2 memory controller out of reset with no processor involved. After reset it waits one settle interval. It then writes a fixed list of words into the controller's configuration space through a simple write port (address, 32-bit data, strobe, ready). The list has three parts:

- PHY start-up: clock enable, PHY reset, calibration start.
- Twelve packed memory commands.
- The timing, latency and general configuration words.

A settle interval follows the PHY clock enable, the calibration start and every command write. When the last configuration word has been accepted, the block raises `done` and stays idle until the next reset.

The settle length, the register addresses, the control bit positions, the command codes and the command arguments are all parameters. A short settle count can therefore be used in simulation. The mode word and the three final configuration words come in on ports and must be held stable while the sequence runs.

Top module: `ddr2_bringup_seq`

## Requirements
- R1: While reset is asserted and right after it, `wr_en` and `done` are low.
- R2: After reset release, `wr_en` stays low for exactly SETTLE_CYC cycles before the first write appears.
- R3: The first three writes are: PHY config address 0x00 with data 0x00000001 (enable bit 0); PHY control address 0x04 with data 0x00000003 (reset bit 0, calibration reset bit 1); and, in the very next cycle, PHY control address 0x04 with data 0x00000004 (calibration start bit 2).
- R4: Every command goes to address 0x08 as one word: code in bits 23:16, argument in bits 15:0, bits 31:24 zero.
- R5: The twelve commands come in this order, with default codes and arguments: deselect 0x0F/0; precharge 0x02/0x0400; EMRS2 0x12/0; EMRS3 0x13/0; EMRS 0x11/DLL-enable 0x0002; MRS 0x10/DLL-reset 0x0100; precharge 0x02/0x0400; refresh 0x01/0; refresh 0x01/0; MRS; EMRS with OCD-default 0x0380|0x0002; EMRS with OCD-exit 0x0000|0x0002.
- R6: After the PHY config write, after the calibration start write and after every command write, `wr_en` stays low for exactly SETTLE_CYC cycles before the next write.
- R7: After the last command, three writes follow in consecutive cycles: timing (address 0x0C), latency (0x10) and configuration (0x14). Each carries the matching input word unchanged.
- R8: The first late MRS carries `mode_word[15:0]`. The final EMRS argument is ORed with `mode_word[31:16]`.
- R9: `done` rises in the cycle after the configuration write is accepted. It stays high until reset, and `wr_en` stays low while `done` is high.
- R10: A write is taken only in a cycle where both `wr_en` and `wr_ready` are high. While `wr_en` is high and `wr_ready` is low, the next cycle keeps `wr_en` high with the same `wr_addr` and `wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_ready | input | 1 | Target accepts the presented write |
| mode_word | input | 32 | Mode word: low half for MRS, high half ORed into the final EMRS |
| timing_word | input | 32 | Value for the timing register |
| latency_word | input | 32 | Value for the latency register |
| cfg_word | input | 32 | Value for the configuration register |
| wr_en | output | 1 | Write strobe |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | 32 | Write data |
| done | output | 1 | Sequence complete; held until reset |

## Verification
The two functions that can land in the same cycle are a stall from the target and the step advance of a back-to-back pair. Those pairs are the PHY reset / calibration start pair and the timing / latency / configuration triple. When they coincide, the sequencer must hold the presented word instead of skipping ahead.

A second run drives `wr_ready` with an irregular pattern so that stalls fall on these zero-gap steps. It then checks three things:
- every stalled cycle kept address and data unchanged;
- the accepted writes still form the exact expected list;
- the settle gaps, counted between accepted writes, are unchanged.

// File: rtl/ddr2_seq_pkg.sv
package ddr2_seq_pkg;
  localparam int NUM_STEPS      = 18;
  localparam int STEP_W         = $clog2(NUM_STEPS);
  localparam int FIRST_CMD_STEP = 3;
  localparam int LAST_CMD_STEP  = 14;

  typedef enum logic [1:0] {
    ST_SETTLE = 2'd0,
    ST_WRITE  = 2'd1,
    ST_DONE   = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic        settle_after;
    logic        is_last;
    logic [31:0] data;
  } step_word_t;
endpackage

// File: rtl/ddr2_seq_timer.sv
module ddr2_seq_timer #(
  parameter int unsigned SETTLE_CYC = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] RELOAD = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expired = (cnt_q == '0);
  assign cnt_en  = load | (run & ~expired);

  always_comb begin
    cnt_d = cnt_q;
    if (load)                cnt_d = RELOAD;
    else if (run && !expired) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= RELOAD;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ddr2_seq_stepctr.sv
module ddr2_seq_stepctr
  import ddr2_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  output logic [STEP_W-1:0] idx
);
  logic [STEP_W-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (advance && (int'(idx_q) < NUM_STEPS - 1)) idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx_q <= '0;
    else if (advance) idx_q <= idx_d;
  end

  assign idx = idx_q;
endmodule

// File: rtl/ddr2_seq_steps.sv
module ddr2_seq_steps
  import ddr2_seq_pkg::*;
#(
  parameter int unsigned ADDR_W        = 8,
  parameter logic [ADDR_W-1:0] ADDR_PHY_CFG  = 'h00,
  parameter logic [ADDR_W-1:0] ADDR_PHY_CTRL = 'h04,
  parameter logic [ADDR_W-1:0] ADDR_CMD      = 'h08,
  parameter logic [ADDR_W-1:0] ADDR_TIMING   = 'h0C,
  parameter logic [ADDR_W-1:0] ADDR_LATENCY  = 'h10,
  parameter logic [ADDR_W-1:0] ADDR_CFG      = 'h14,
  parameter int unsigned PHY_EN_BIT     = 0,
  parameter int unsigned PHY_RST_BIT    = 0,
  parameter int unsigned PHY_CALRST_BIT = 1,
  parameter int unsigned PHY_CALGO_BIT  = 2,
  parameter logic [7:0]  CODE_DESEL = 8'h0F,
  parameter logic [7:0]  CODE_PRE   = 8'h02,
  parameter logic [7:0]  CODE_REF   = 8'h01,
  parameter logic [7:0]  CODE_MRS   = 8'h10,
  parameter logic [7:0]  CODE_EMRS  = 8'h11,
  parameter logic [7:0]  CODE_EMRS2 = 8'h12,
  parameter logic [7:0]  CODE_EMRS3 = 8'h13,
  parameter logic [15:0] ARG_PRE_ALL  = 16'h0400,
  parameter logic [15:0] ARG_DLL_EN   = 16'h0002,
  parameter logic [15:0] ARG_DLL_RST  = 16'h0100,
  parameter logic [15:0] ARG_OCD_DFLT = 16'h0380,
  parameter logic [15:0] ARG_OCD_EXIT = 16'h0000
) (
  input  logic [STEP_W-1:0] step_idx,
  input  logic [31:0]       mode_word,
  input  logic [31:0]       timing_word,
  input  logic [31:0]       latency_word,
  input  logic [31:0]       cfg_word,
  output logic [ADDR_W-1:0] step_addr,
  output step_word_t        step
);
  localparam logic [31:0] PHY_EN_WORD  = 32'(1) << PHY_EN_BIT;
  localparam logic [31:0] PHY_RST_WORD = (32'(1) << PHY_RST_BIT) | (32'(1) << PHY_CALRST_BIT);
  localparam logic [31:0] PHY_GO_WORD  = 32'(1) << PHY_CALGO_BIT;

  function automatic logic [31:0] pack_cmd(input logic [7:0] code, input logic [15:0] arg);
    return {8'h00, code, arg};
  endfunction

  logic [7:0]  cmd_code;
  logic [15:0] cmd_arg;
  int          k;

  // command list, position relative to FIRST_CMD_STEP
  always_comb begin
    k        = int'(step_idx) - FIRST_CMD_STEP;
    cmd_code = CODE_DESEL;
    cmd_arg  = 16'h0000;
    case (k)
      0:  begin cmd_code = CODE_DESEL; cmd_arg = 16'h0000; end
      1:  begin cmd_code = CODE_PRE;   cmd_arg = ARG_PRE_ALL; end
      2:  begin cmd_code = CODE_EMRS2; cmd_arg = 16'h0000; end
      3:  begin cmd_code = CODE_EMRS3; cmd_arg = 16'h0000; end
      4:  begin cmd_code = CODE_EMRS;  cmd_arg = ARG_DLL_EN; end
      5:  begin cmd_code = CODE_MRS;   cmd_arg = ARG_DLL_RST; end
      6:  begin cmd_code = CODE_PRE;   cmd_arg = ARG_PRE_ALL; end
      7:  begin cmd_code = CODE_REF;   cmd_arg = 16'h0000; end
      8:  begin cmd_code = CODE_REF;   cmd_arg = 16'h0000; end
      9:  begin cmd_code = CODE_MRS;   cmd_arg = mode_word[15:0]; end
      10: begin cmd_code = CODE_EMRS;  cmd_arg = ARG_OCD_DFLT | ARG_DLL_EN; end
      11: begin cmd_code = CODE_EMRS;  cmd_arg = ARG_OCD_EXIT | ARG_DLL_EN | mode_word[31:16]; end
      default: begin cmd_code = CODE_DESEL; cmd_arg = 16'h0000; end
    endcase
  end

  always_comb begin
    step_addr         = '0;
    step.data         = '0;
    step.settle_after = 1'b0;
    step.is_last      = 1'b0;
    case (int'(step_idx))
      0: begin step_addr = ADDR_PHY_CFG;  step.data = PHY_EN_WORD;  step.settle_after = 1'b1; end
      1: begin step_addr = ADDR_PHY_CTRL; step.data = PHY_RST_WORD; end
      2: begin step_addr = ADDR_PHY_CTRL; step.data = PHY_GO_WORD;  step.settle_after = 1'b1; end
      15: begin step_addr = ADDR_TIMING;  step.data = timing_word; end
      16: begin step_addr = ADDR_LATENCY; step.data = latency_word; end
      17: begin step_addr = ADDR_CFG;     step.data = cfg_word; step.is_last = 1'b1; end
      default: begin
        if (int'(step_idx) >= FIRST_CMD_STEP && int'(step_idx) <= LAST_CMD_STEP) begin
          step_addr         = ADDR_CMD;
          step.data         = pack_cmd(cmd_code, cmd_arg);
          step.settle_after = 1'b1;
        end
      end
    endcase
  end
endmodule

// File: rtl/ddr2_bringup_seq.sv
module ddr2_bringup_seq
  import ddr2_seq_pkg::*;
#(
  parameter int unsigned SETTLE_CYC    = 10000,
  parameter int unsigned ADDR_W        = 8,
  parameter logic [ADDR_W-1:0] ADDR_PHY_CFG  = 'h00,
  parameter logic [ADDR_W-1:0] ADDR_PHY_CTRL = 'h04,
  parameter logic [ADDR_W-1:0] ADDR_CMD      = 'h08,
  parameter logic [ADDR_W-1:0] ADDR_TIMING   = 'h0C,
  parameter logic [ADDR_W-1:0] ADDR_LATENCY  = 'h10,
  parameter logic [ADDR_W-1:0] ADDR_CFG      = 'h14,
  parameter int unsigned PHY_EN_BIT     = 0,
  parameter int unsigned PHY_RST_BIT    = 0,
  parameter int unsigned PHY_CALRST_BIT = 1,
  parameter int unsigned PHY_CALGO_BIT  = 2,
  parameter logic [7:0]  CODE_DESEL = 8'h0F,
  parameter logic [7:0]  CODE_PRE   = 8'h02,
  parameter logic [7:0]  CODE_REF   = 8'h01,
  parameter logic [7:0]  CODE_MRS   = 8'h10,
  parameter logic [7:0]  CODE_EMRS  = 8'h11,
  parameter logic [7:0]  CODE_EMRS2 = 8'h12,
  parameter logic [7:0]  CODE_EMRS3 = 8'h13,
  parameter logic [15:0] ARG_PRE_ALL  = 16'h0400,
  parameter logic [15:0] ARG_DLL_EN   = 16'h0002,
  parameter logic [15:0] ARG_DLL_RST  = 16'h0100,
  parameter logic [15:0] ARG_OCD_DFLT = 16'h0380,
  parameter logic [15:0] ARG_OCD_EXIT = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ready,
  input  logic [31:0]       mode_word,
  input  logic [31:0]       timing_word,
  input  logic [31:0]       latency_word,
  input  logic [31:0]       cfg_word,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  output logic              done
);
  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_idx;
  step_word_t        step;
  logic [ADDR_W-1:0] step_addr;
  logic              accept, tmr_load, tmr_run, tmr_expired, advance;

  ddr2_seq_steps #(
    .ADDR_W(ADDR_W),
    .ADDR_PHY_CFG(ADDR_PHY_CFG), .ADDR_PHY_CTRL(ADDR_PHY_CTRL), .ADDR_CMD(ADDR_CMD),
    .ADDR_TIMING(ADDR_TIMING), .ADDR_LATENCY(ADDR_LATENCY), .ADDR_CFG(ADDR_CFG),
    .PHY_EN_BIT(PHY_EN_BIT), .PHY_RST_BIT(PHY_RST_BIT),
    .PHY_CALRST_BIT(PHY_CALRST_BIT), .PHY_CALGO_BIT(PHY_CALGO_BIT),
    .CODE_DESEL(CODE_DESEL), .CODE_PRE(CODE_PRE), .CODE_REF(CODE_REF),
    .CODE_MRS(CODE_MRS), .CODE_EMRS(CODE_EMRS), .CODE_EMRS2(CODE_EMRS2), .CODE_EMRS3(CODE_EMRS3),
    .ARG_PRE_ALL(ARG_PRE_ALL), .ARG_DLL_EN(ARG_DLL_EN), .ARG_DLL_RST(ARG_DLL_RST),
    .ARG_OCD_DFLT(ARG_OCD_DFLT), .ARG_OCD_EXIT(ARG_OCD_EXIT)
  ) u_steps (
    .step_idx(step_idx), .mode_word(mode_word), .timing_word(timing_word),
    .latency_word(latency_word), .cfg_word(cfg_word),
    .step_addr(step_addr), .step(step)
  );

  ddr2_seq_stepctr u_ctr (
    .clk(clk), .rst_n(rst_n), .advance(advance), .idx(step_idx)
  );

  ddr2_seq_timer #(.SETTLE_CYC(SETTLE_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .run(tmr_run), .expired(tmr_expired)
  );

  assign accept   = (state_q == ST_WRITE) & wr_ready;
  assign advance  = accept & ~step.is_last;
  assign tmr_load = accept & step.settle_after & ~step.is_last;
  assign tmr_run  = (state_q == ST_SETTLE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_SETTLE: if (tmr_expired) state_d = ST_WRITE;
      ST_WRITE: begin
        if (accept) begin
          if (step.is_last)           state_d = ST_DONE;
          else if (step.settle_after) state_d = ST_SETTLE;
          else                        state_d = ST_WRITE;
        end
      end
      ST_DONE:  state_d = ST_DONE;
      default:  state_d = ST_SETTLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_SETTLE;
    else        state_q <= state_d;
  end

  assign wr_en   = (state_q == ST_WRITE);
  assign wr_addr = step_addr;
  assign wr_data = step.data;
  assign done    = (state_q == ST_DONE);
endmodule

// File: rtl/ddr2_bringup_seq_chk.sv
module ddr2_bringup_seq_chk #(
  parameter int unsigned ADDR_W         = 8,
  parameter int unsigned SETTLE_CYC     = 10000,
  parameter logic [ADDR_W-1:0] ADDR_PHY_CTRL = 'h04,
  parameter logic [ADDR_W-1:0] ADDR_CFG      = 'h14,
  parameter int unsigned PHY_RST_BIT    = 0,
  parameter int unsigned PHY_CALRST_BIT = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic              done
);
  localparam logic [31:0] RST_WORD = (32'(1) << PHY_RST_BIT) | (32'(1) << PHY_CALRST_BIT);

  logic [31:0] idle_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    idle_q <= '0;
    else if (wr_en)                idle_q <= '0;
    else if (idle_q != 32'hFFFF_FFFF) idle_q <= idle_q + 1'b1;
  end

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_ready |=> wr_en && $stable(wr_addr) && $stable(wr_data));

  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R9
  quiet_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_en);

  // R9
  done_after_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(wr_en && wr_ready && (wr_addr == ADDR_CFG)));

  // R2 R6
  settle_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (idle_q != 0) |-> idle_q == 32'(SETTLE_CYC));

  // R3
  cal_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_ready && (wr_addr == ADDR_PHY_CTRL) && (wr_data == RST_WORD)
    |=> wr_en && (wr_addr == ADDR_PHY_CTRL));
endmodule

bind ddr2_bringup_seq ddr2_bringup_seq_chk #(
  .ADDR_W(ADDR_W), .SETTLE_CYC(SETTLE_CYC), .ADDR_PHY_CTRL(ADDR_PHY_CTRL),
  .ADDR_CFG(ADDR_CFG), .PHY_RST_BIT(PHY_RST_BIT), .PHY_CALRST_BIT(PHY_CALRST_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
);

// File: tb/ddr2_bringup_seq_tb.sv
module ddr2_bringup_seq_tb;
  localparam int D = 8;
  localparam int NW = 18;
  localparam logic [31:0] MODE = 32'h0044_0A63;
  localparam logic [31:0] TIMW = 32'h1234_5678;
  localparam logic [31:0] LATW = 32'h0000_0035;
  localparam logic [31:0] CFGW = 32'h8000_0C21;

  // {addr[7:0], data[31:0], gap[15:0]}
  localparam logic [55:0] EXP [NW] = '{
    {8'h00, 32'h0000_0001, 16'(D)},
    {8'h04, 32'h0000_0003, 16'(D)},
    {8'h04, 32'h0000_0004, 16'd0},
    {8'h08, 32'h000F_0000, 16'(D)},
    {8'h08, 32'h0002_0400, 16'(D)},
    {8'h08, 32'h0012_0000, 16'(D)},
    {8'h08, 32'h0013_0000, 16'(D)},
    {8'h08, 32'h0011_0002, 16'(D)},
    {8'h08, 32'h0010_0100, 16'(D)},
    {8'h08, 32'h0002_0400, 16'(D)},
    {8'h08, 32'h0001_0000, 16'(D)},
    {8'h08, 32'h0001_0000, 16'(D)},
    {8'h08, {16'h0010, MODE[15:0]}, 16'(D)},
    {8'h08, 32'h0011_0382, 16'(D)},
    {8'h08, {16'h0011, 16'h0002 | MODE[31:16]}, 16'(D)},
    {8'h0C, TIMW, 16'(D)},
    {8'h10, LATW, 16'd0},
    {8'h14, CFGW, 16'd0}
  };

  logic clk, rst_n, wr_ready, wr_en, done;
  logic [7:0]  wr_addr;
  logic [31:0] wr_data;
  int n_checks, n_fail;
  bit stall_en, finished;

  logic [7:0]  got_addr [NW];
  logic [31:0] got_data [NW];
  int          got_gap  [NW];
  int n_acc, gapcnt;
  bit prev_stall, done_due;
  logic [7:0]  prev_addr;
  logic [31:0] prev_data;

  ddr2_bringup_seq #(.SETTLE_CYC(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_ready(wr_ready), .mode_word(MODE),
    .timing_word(TIMW), .latency_word(LATW), .cfg_word(CFGW),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: samples at the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      n_acc = 0; gapcnt = 0; prev_stall = 0; done_due = 0;
    end else begin
      if (done_due) begin
        chk("R9", "done one cycle after config write", 64'(done), 64'd1);
        done_due = 0;
      end
      if (prev_stall) begin
        chk("R10", "strobe held in stall", 64'(wr_en), 64'd1);
        chk("R10", "addr held in stall", 64'(wr_addr), 64'(prev_addr));
        chk("R10", "data held in stall", 64'(wr_data), 64'(prev_data));
      end
      if (done && wr_en) chk("R9", "write after done", 64'(wr_en), 64'd0);
      if (wr_en && wr_ready) begin
        if (n_acc < NW) begin
          got_addr[n_acc] = wr_addr; got_data[n_acc] = wr_data; got_gap[n_acc] = gapcnt;
        end
        chk("R9", "done low before end", 64'(done), 64'd0);
        n_acc++; gapcnt = 0;
        if (n_acc == NW) done_due = 1;
      end else if (!wr_en) begin
        gapcnt++;
      end
      prev_stall = wr_en && !wr_ready;
      prev_addr = wr_addr; prev_data = wr_data;
    end
  end

  // target readiness driver
  initial begin
    wr_ready = 1'b1;
    for (int k = 0; ; k++) begin
      @(posedge clk); #2;
      wr_ready = stall_en ? (((k * 7) % 5) < 2) : 1'b1;
    end
  end

  function automatic string tag_of(input int i, input bit is_gap);
    if (is_gap) return (i == 0) ? "R2" : ((i == 2 || i >= 16) ? "R7/R3 no-gap" : "R6");
    if (i < 3) return "R3";
    if (i == 12 || i == 14) return "R8";
    if (i < 15) return "R5 R4";
    return "R7";
  endfunction

  task automatic wait_done(input int limit);
    int c = 0;
    while (!done && c < limit) begin @(negedge clk); c++; end
    repeat (2) @(negedge clk);
    chk("R9", "sequence finished (watchdog)", 64'(done), 64'd1);
  endtask

  task automatic check_table(input string run);
    chk("R9", {run, " accepted write count"}, 64'(n_acc), 64'(NW));
    for (int i = 0; i < NW; i++) begin
      chk(tag_of(i, 0), $sformatf("%s addr #%0d", run, i), 64'(got_addr[i]), 64'(EXP[i][55:48]));
      chk(tag_of(i, 0), $sformatf("%s data #%0d", run, i), 64'(got_data[i]), 64'(EXP[i][47:16]));
      chk(tag_of(i, 1), $sformatf("%s gap #%0d", run, i), 64'(got_gap[i]), 64'(EXP[i][15:0]));
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #2; rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "wr_en in reset", 64'(wr_en), 64'd0);
    chk("R1", "done in reset", 64'(done), 64'd0);
    #1; rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "wr_en after release", 64'(wr_en), 64'd0);
  endtask

  initial begin
    n_checks = 0; n_fail = 0; stall_en = 0; finished = 0; rst_n = 1'b0;
    // run 1: target always ready
    do_reset();
    wait_done(2000);
    check_table("ready");
    repeat (20) @(negedge clk);
    chk("R9", "done held", 64'(done), 64'd1);
    chk("R9", "no extra writes", 64'(n_acc), 64'(NW));
    // run 2: stalls landing on zero-gap steps
    stall_en = 1;
    do_reset();
    wait_done(4000);
    check_table("stall");
    stall_en = 0;
    // run 3: reset in mid-sequence, then full restart
    do_reset();
    repeat (40) @(negedge clk);
    do_reset();
    wait_done(2000);
    check_table("restart");
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule